// File: doc/BRIEF.md
# Word FIFO Byte Packing Data Path

This block moves data between a software-visible FIFO of 32-bit words and a card data port that carries one byte at a time. Software programs a byte length and then writes the data control register with the run bit set. The block then loads a byte counter for the card side and a word counter for the software side. In the card-to-FIFO direction, incoming bytes are packed little-endian into words. A short final word is pushed with its upper bytes zero. In the FIFO-to-card direction, each word is popped and sent lowest byte first. Bytes past the programmed length are discarded.

Software reaches the FIFO through a window of word addresses. Each access in the window moves exactly one word. The block reports FIFO occupancy flags for the active direction only, and it raises sticky data-end and block-end bits when the byte counter runs out. The run bit clears itself once both counters reach zero. Pushes or pops that cannot be honoured are dropped, and they raise a sticky error output.

Register offsets: 0x00 length (16 bits), 0x04 data control (8 bits), 0x08 byte counter (read only), 0x0C word counter (read only), 0x10 status (read only). Data window: 0x80 to 0xBC, word aligned. Reads return data on `bus_rdata` from the clock edge that samples `bus_rd`.

Top module: `wbm_engine`

## Requirements
- R1: After reset, the length, control, byte counter, word counter, status and error are all zero, `card_rx_ready` is 0 and `card_tx_valid` is 0.
- R2: Writing data control with bit 0 (run) set loads the byte counter with the length and the word counter with (length + 3) / 4. Control keeps bits 7:0, with bit 1 as direction (1 = card to FIFO), and the length register keeps 16 bits.
- R3: In the card-to-FIFO direction, byte n of a word goes to bits 8n+7:8n, and every fourth byte completes a push. When the byte counter runs out, a partial word is pushed with zero upper bytes.
- R4: In the FIFO-to-card direction, each popped word is sent on `card_tx_data` from bits 7:0 upward. Bytes of the last word beyond the byte counter are never sent.
- R5: Card-to-FIFO transfer stalls (`card_rx_ready` = 0) while the FIFO holds DEPTH words. FIFO-to-card transfer stalls (`card_tx_valid` = 0) while the FIFO is empty and no unpacked byte is left.
- R6: Each data-window access decrements the word counter and pushes the write data or pops one word into `bus_rdata`. An access while the word counter is zero changes nothing, and a read in that state returns 0.
- R7: While run is set and the byte counter is zero, status bits 8 (data end) and 10 (block end) become set. They stay set until the next write of control with run set.
- R8: Once run is set and both counters are zero, the run bit clears on the next cycle.
- R9: While run is set and a counter is non-zero, the status flags follow the FIFO count: active, at most DEPTH/2 (transmit) or at least DEPTH/2 (receive), full, empty and non-empty. Transmit flags sit at bits 12, 14, 16, 18, 20 and receive flags at bits 13, 15, 17, 19, 21. Only the current direction's set is ever non-zero, and all of them are zero when idle.
- R10: A push into a full FIFO, a pop from an empty FIFO, or a software access that collides with an engine access on the same FIFO port is dropped without disturbing the stored words, and it sets `xfer_err`, which stays set until reset.
- R11: At most one byte crosses the card port per clock, on a cycle where valid and ready are both high, and each such byte decrements the byte counter by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register or window write strobe |
| bus_rd | input | 1 | Register or window read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| card_rx_valid | input | 1 | Card offers a byte toward the FIFO |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_ready | output | 1 | Block accepts the card byte |
| card_tx_valid | output | 1 | Block offers a byte to the card |
| card_tx_data | output | 8 | Byte to the card |
| card_tx_ready | input | 1 | Card accepts the byte |
| status | output | 22 | Status bits (end flags and direction flags) |
| xfer_err | output | 1 | Sticky dropped-access indicator |

## Verification
Two functions can land on the same clock edge: the packer pushing a completed word from the card stream, and a software data-window read popping the FIFO head. The bench provokes this by running an 80-byte card-to-FIFO transfer until the FIFO is full and the card side stalls. It then drains the FIFO with reads issued whenever the data-available flag is up, while the card keeps streaming, so reads and packer pushes repeatedly share an edge. The result is judged by requiring every one of the 20 words read back to equal the little-endian packing of the byte stream, in order, with the error output still clear and the run bit dropped at the end.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
   // status layout: end flags, then direction flags interleaved (tx even, rx odd)
   localparam int ST_DATA_END   = 8;
   localparam int ST_BLOCK_END  = 10;
   localparam int ST_FLAG_BASE  = 12;
   localparam int FL_KINDS      = 5;   // active, half, full, empty, non-empty
   localparam int STAT_W        = ST_FLAG_BASE + 2 * FL_KINDS;

   localparam int FL_ACTIVE = 0;
   localparam int FL_HALF   = 1;
   localparam int FL_FULL   = 2;
   localparam int FL_EMPTY  = 3;
   localparam int FL_AVAIL  = 4;

   localparam logic [7:0] A_LEN  = 8'h00;
   localparam logic [7:0] A_CTRL = 8'h04;
   localparam logic [7:0] A_BCNT = 8'h08;
   localparam logic [7:0] A_WCNT = 8'h0C;
   localparam logic [7:0] A_STAT = 8'h10;
   localparam logic [7:0] WIN_LO = 8'h80;
   localparam logic [7:0] WIN_HI = 8'hBC;

   typedef struct packed {
      logic [3:0] spare;
      logic       dma;
      logic       mode;
      logic       to_host;
      logic       run;
   } ctrl_t;
endpackage

// File: rtl/wbm_fifo.sv
module wbm_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               push_data,
   input  logic                       pop,
   output logic [W-1:0]               head,
   output logic [$clog2(DEPTH):0]     count,
   output logic                       full,
   output logic                       empty,
   output logic                       drop
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("wbm_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd_ptr, wr_ptr;
   logic          do_push, do_pop;

   assign full    = (count == FULL_CNT);
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign drop    = (push && full) || (pop && empty);
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R10
   overflow_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (count == FULL_CNT));
   // R10
   underflow_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> (count == '0));
endmodule

// File: rtl/wbm_rx_pack.sv
module wbm_rx_pack #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic         take,
   input  logic         last,
   input  logic [7:0]   byte_in,
   output logic         push,
   output logic [W-1:0] word
);
   localparam int NB = W / 8;
   localparam int IW = (NB > 1) ? $clog2(NB) : 1;

   if (W % 8 != 0 || NB < 1) begin : g_bad_width
      $error("wbm_rx_pack: W must be a whole number of bytes");
   end

   logic [W-1:0]  acc;
   logic [IW-1:0] idx;
   logic [W-1:0]  placed;

   // little-endian placement: byte idx lands at bits 8*idx+7 : 8*idx
   assign placed = {{(W-8){1'b0}}, byte_in} << {idx, 3'b000};
   assign word   = acc | placed;
   assign push   = take && ((idx == IW'(NB - 1)) || last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         idx <= '0;
      end else if (restart) begin
         acc <= '0;
         idx <= '0;
      end else if (take) begin
         if (push) begin
            acc <= '0;
            idx <= '0;
         end else begin
            acc <= word;
            idx <= idx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/wbm_tx_unpack.sv
module wbm_tx_unpack #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic [W-1:0] head,
   input  logic         fifo_has,
   input  logic         give,
   output logic         have_byte,
   output logic [7:0]   byte_out,
   output logic         pop
);
   localparam int NB = W / 8;
   localparam int IW = (NB > 1) ? $clog2(NB) : 1;

   logic [W-1:0]  rest;
   logic [IW-1:0] left;
   logic          holding;

   assign holding   = (left != '0);
   assign have_byte = holding || fifo_has;
   assign byte_out  = holding ? rest[7:0] : head[7:0];
   assign pop       = give && !holding;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rest <= '0;
         left <= '0;
      end else if (restart) begin
         rest <= '0;
         left <= '0;
      end else if (give) begin
         if (!holding) begin
            rest <= head >> 8;
            left <= IW'(NB - 1);
         end else begin
            rest <= rest >> 8;
            left <= left - 1'b1;
         end
      end
   end
endmodule

// File: rtl/wbm_flags.sv
module wbm_flags
   import wbm_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic                      active,
   input  logic                      to_host,
   input  logic [$clog2(DEPTH):0]    count,
   output logic [STAT_W-1:0]         flags
);
   localparam int CW   = $clog2(DEPTH) + 1;
   localparam int HALF = DEPTH / 2;

   logic [FL_KINDS-1:0] tx_c, rx_c;

   always_comb begin
      tx_c[FL_ACTIVE] = 1'b1;
      tx_c[FL_HALF]   = (count <= CW'(HALF));
      tx_c[FL_FULL]   = (count == CW'(DEPTH));
      tx_c[FL_EMPTY]  = (count == '0);
      tx_c[FL_AVAIL]  = (count != '0);
      rx_c            = tx_c;
      rx_c[FL_HALF]   = (count >= CW'(HALF));
   end

   assign flags[ST_FLAG_BASE-1:0] = '0;

   for (genvar k = 0; k < FL_KINDS; k++) begin : g_kind
      assign flags[ST_FLAG_BASE + 2*k]     = active && !to_host && tx_c[k];
      assign flags[ST_FLAG_BASE + 2*k + 1] = active &&  to_host && rx_c[k];
   end
endmodule

// File: rtl/wbm_engine.sv
module wbm_engine
   import wbm_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 32,
   parameter int LEN_W  = 16,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              card_rx_valid,
   input  logic [7:0]        card_rx_data,
   output logic              card_rx_ready,
   output logic              card_tx_valid,
   output logic [7:0]        card_tx_data,
   input  logic              card_tx_ready,
   output logic [STAT_W-1:0] status,
   output logic              xfer_err
);
   localparam int NB   = DATA_W / 8;
   localparam int SH   = $clog2(NB);
   localparam int WC_W = LEN_W - SH + 1;
   localparam int CW   = $clog2(DEPTH) + 1;

   if (DATA_W < STAT_W || DATA_W % 8 != 0 || (NB & (NB - 1)) != 0) begin : g_bad_data
      $error("wbm_engine: DATA_W must be a power-of-two byte count covering status");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("wbm_engine: ADDR_W must reach the data window");
   end
   if (LEN_W < SH + 1 || LEN_W > DATA_W) begin : g_bad_len
      $error("wbm_engine: LEN_W out of range");
   end

   // ---------------- register state ----------------
   logic [LEN_W-1:0]  len_q;
   ctrl_t             ctrl_q;
   logic [LEN_W-1:0]  bcnt;
   logic [WC_W-1:0]   wcnt;
   logic              fin_q;
   logic              err_q;
   logic [DATA_W-1:0] rdata_q;

   // ---------------- decode ----------------
   logic in_win, ctrl_wr, restart, sw_wr, sw_rd;
   logic [LEN_W:0]  len_rnd;
   logic [WC_W-1:0] wcnt_load;

   assign in_win  = (bus_addr >= ADDR_W'(WIN_LO)) && (bus_addr <= ADDR_W'(WIN_HI))
                    && (bus_addr[1:0] == 2'b00);
   assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
   assign restart = ctrl_wr && bus_wdata[0];
   assign sw_wr   = bus_wr && in_win && (wcnt != '0);
   assign sw_rd   = bus_rd && in_win && (wcnt != '0);

   assign len_rnd   = {1'b0, len_q} + (LEN_W+1)'(NB - 1);
   assign wcnt_load = WC_W'(len_rnd >> SH);

   // ---------------- FIFO and byte engines ----------------
   logic              f_push, f_pop, f_full, f_empty, f_drop;
   logic [DATA_W-1:0] f_head, f_wdata;
   logic [CW-1:0]     f_count;
   logic              pk_push, up_pop, up_have;
   logic [DATA_W-1:0] pk_word;
   logic              rx_go, rx_fire, tx_fire, last_byte, conflict;

   assign last_byte     = (bcnt == LEN_W'(1));
   assign rx_go         = ctrl_q.run && ctrl_q.to_host && (bcnt != '0) && !f_full && !ctrl_wr;
   assign card_rx_ready = rx_go;
   assign rx_fire       = rx_go && card_rx_valid;
   assign card_tx_valid = ctrl_q.run && !ctrl_q.to_host && (bcnt != '0) && up_have && !ctrl_wr;
   assign tx_fire       = card_tx_valid && card_tx_ready;

   assign f_push   = pk_push || sw_wr;
   assign f_wdata  = pk_push ? pk_word : bus_wdata;
   assign f_pop    = up_pop || sw_rd;
   assign conflict = (pk_push && sw_wr) || (up_pop && sw_rd);

   wbm_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(f_push), .push_data(f_wdata), .pop(f_pop),
      .head(f_head), .count(f_count), .full(f_full), .empty(f_empty), .drop(f_drop)
   );

   wbm_rx_pack #(.W(DATA_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .restart(restart),
      .take(rx_fire), .last(last_byte), .byte_in(card_rx_data),
      .push(pk_push), .word(pk_word)
   );

   wbm_tx_unpack #(.W(DATA_W)) u_unpack (
      .clk(clk), .rst_n(rst_n), .restart(restart),
      .head(f_head), .fifo_has(!f_empty), .give(tx_fire),
      .have_byte(up_have), .byte_out(card_tx_data), .pop(up_pop)
   );

   // ---------------- status ----------------
   logic              active;
   logic [STAT_W-1:0] dir_flags;

   assign active = ctrl_q.run && !((bcnt == '0) && (wcnt == '0));

   wbm_flags #(.DEPTH(DEPTH)) u_flags (
      .active(active), .to_host(ctrl_q.to_host), .count(f_count), .flags(dir_flags)
   );

   assign status   = dir_flags | (STAT_W'(fin_q) << ST_DATA_END)
                               | (STAT_W'(fin_q) << ST_BLOCK_END);
   assign xfer_err = err_q;

   // ---------------- sequential control ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q  <= '0;
         ctrl_q <= '0;
         bcnt   <= '0;
         wcnt   <= '0;
         fin_q  <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (bus_wr && bus_addr == ADDR_W'(A_LEN)) len_q <= bus_wdata[LEN_W-1:0];

         if (ctrl_wr)
            ctrl_q <= ctrl_t'(bus_wdata[7:0]);
         else if (ctrl_q.run && bcnt == '0 && wcnt == '0)
            ctrl_q.run <= 1'b0;

         if (restart) begin
            bcnt  <= len_q;
            wcnt  <= wcnt_load;
            fin_q <= 1'b0;
         end else begin
            if (rx_fire || tx_fire) bcnt <= bcnt - 1'b1;
            if (sw_wr || sw_rd)     wcnt <= wcnt - 1'b1;
            if (ctrl_q.run && bcnt == '0) fin_q <= 1'b1;
         end

         if (f_drop || conflict) err_q <= 1'b1;
      end
   end

   // ---------------- read path ----------------
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      if (in_win) begin
         if (sw_rd && !f_empty && !up_pop) rd_mux = f_head;
      end else begin
         case (bus_addr)
            ADDR_W'(A_LEN):  rd_mux = DATA_W'(len_q);
            ADDR_W'(A_CTRL): rd_mux = DATA_W'(ctrl_q);
            ADDR_W'(A_BCNT): rd_mux = DATA_W'(bcnt);
            ADDR_W'(A_WCNT): rd_mux = DATA_W'(wcnt);
            ADDR_W'(A_STAT): rd_mux = DATA_W'(status);
            default:         rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_rd) rdata_q <= rd_mux;
   end
   assign bus_rdata = rdata_q;

   // ---------------- assertions ----------------
   // R8
   run_autoclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.run && bcnt == '0 && wcnt == '0 && !ctrl_wr) |=> !ctrl_q.run);
   // R7
   end_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.run && bcnt == '0 && !ctrl_wr) |=> (status[ST_DATA_END] && status[ST_BLOCK_END]));
   // R5
   rx_stall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      card_rx_ready |-> (f_count < CW'(DEPTH)));
   // R9
   full_flag_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status[ST_FLAG_BASE + 2*FL_FULL + 1] |-> !card_rx_ready);
   // R4
   unpack_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_pop |-> !f_empty);
   // R11
   one_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_fire || tx_fire) |=> (bcnt == $past(bcnt) - LEN_W'(1)));
endmodule

// File: tb/wbm_engine_test.sv
module wbm_engine_test;
   import wbm_pkg::*;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_valid, rx_ready, tx_valid;
   logic        tx_ready = 1'b0;
   logic [7:0]  rx_data, tx_data;
   logic [21:0] status;
   logic        xfer_err;

   wbm_engine uut (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .card_rx_valid(rx_valid), .card_rx_data(rx_data), .card_rx_ready(rx_ready),
      .card_tx_valid(tx_valid), .card_tx_data(tx_data), .card_tx_ready(tx_ready),
      .status(status), .xfer_err(xfer_err)
   );

   int total = 0, bad = 0;
   bit finished = 1'b0;

   // card source model
   logic [7:0] src [0:127];
   int         src_n = 0, src_idx = 0;
   logic       src_clr = 1'b0;
   assign rx_valid = (src_idx < src_n);
   assign rx_data  = (src_idx < 128) ? src[src_idx] : 8'h00;
   always @(posedge clk) begin
      if (src_clr) src_idx <= 0;
      else if (rx_valid && rx_ready) src_idx <= src_idx + 1;
   end

   // card sink model
   logic [7:0] snk [0:127];
   int         snk_n = 0;
   logic       snk_clr = 1'b0;
   always @(posedge clk) begin
      if (snk_clr) snk_n <= 0;
      else if (tx_valid && tx_ready && snk_n < 128) begin
         snk[snk_n] <= tx_data;
         snk_n <= snk_n + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic clear_streams();
      @(negedge clk);
      src_clr = 1'b1; snk_clr = 1'b1;
      @(negedge clk);
      src_clr = 1'b0; snk_clr = 1'b0;
   endtask

   task automatic wait_avail();
      int guard = 0;
      while (!status[21] && guard < 1000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 status", 32'(status), 32'h0);
      chk("R1 rx_ready", 32'(rx_ready), 32'h0);
      chk("R1 tx_valid", 32'(tx_valid), 32'h0);
      chk("R1 err", 32'(xfer_err), 32'h0);
      bus_read(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
      bus_read(A_LEN, v);  chk("R1 len", v, 32'h0);
      bus_read(A_WCNT, v); chk("R1 wcnt", v, 32'h0);
   endtask

   task automatic t_zero_len();
      logic [31:0] v;
      bus_write(A_LEN, 32'h0);
      bus_write(A_CTRL, 32'h03);
      repeat (2) @(negedge clk);
      bus_read(A_CTRL, v); chk("R8 zero length run clears", v, 32'h02);
      chk("R7 zero length end bits", 32'(status), 32'h500);
   endtask

   task automatic t_rx_short();
      logic [31:0] v;
      for (int i = 0; i < 10; i++) src[i] = 8'(8'h11 + i);
      src_n = 10;
      clear_streams();
      bus_write(A_LEN, 32'h1_000A);
      bus_read(A_LEN, v); chk("R2 length keeps 16 bits", v, 32'h000A);
      bus_write(A_CTRL, 32'h03);
      bus_read(A_WCNT, v); chk("R2 word count load", v, 32'd3);
      repeat (30) @(negedge clk);
      chk("R5 source consumed exactly", 32'(src_idx), 32'd10);
      chk("R9 rx flags with 3 words", 32'(status), 32'h0020_2500);
      bus_read(8'h80, v); chk("R3 word0", v, 32'h1413_1211);
      bus_read(8'hA4, v); chk("R3 word1", v, 32'h1817_1615);
      bus_read(8'hBC, v); chk("R3 partial word", v, 32'h0000_1A19);
      repeat (2) @(negedge clk);
      chk("R9 flags cleared when idle", 32'(status), 32'h500);
      bus_read(A_CTRL, v); chk("R8 run cleared", v, 32'h02);
      bus_read(8'h80, v); chk("R6 read at zero count", v, 32'h0);
      chk("R6 ignored read no error", 32'(xfer_err), 32'h0);
   endtask

   task automatic t_tx_short();
      logic [31:0] v;
      tx_ready = 1'b1;
      clear_streams();
      bus_write(A_LEN, 32'd7);
      bus_write(A_CTRL, 32'h01);
      chk("R9 tx flags empty", 32'(status), 32'h0004_5000);
      chk("R5 tx stall when empty", 32'(tx_valid), 32'h0);
      bus_write(8'h84, 32'hA3A2_A1A0);
      bus_write(8'h88, 32'hEEB2_B1B0);
      repeat (20) @(negedge clk);
      chk("R4 byte count sent", 32'(snk_n), 32'd7);
      chk("R4 b0", 32'(snk[0]), 32'hA0);
      chk("R4 b3", 32'(snk[3]), 32'hA3);
      chk("R4 b4", 32'(snk[4]), 32'hB0);
      chk("R4 b6", 32'(snk[6]), 32'hB2);
      chk("R8 tx done status", 32'(status), 32'h500);
      bus_read(A_CTRL, v); chk("R8 tx run cleared", v, 32'h00);
      bus_write(8'h80, 32'h1234_5678);
      repeat (5) @(negedge clk);
      chk("R6 ignored write sends nothing", 32'(snk_n), 32'd7);
      chk("R6 ignored write no error", 32'(xfer_err), 32'h0);
   endtask

   task automatic t_tx_half();
      logic ok = 1'b1;
      tx_ready = 1'b0;
      clear_streams();
      bus_write(A_LEN, 32'd36);
      bus_write(A_CTRL, 32'h01);
      for (int k = 0; k < 8; k++)
         bus_write(8'h80, {8'(4*k+3+8'h40), 8'(4*k+2+8'h40), 8'(4*k+1+8'h40), 8'(4*k+8'h40)});
      chk("R9 tx half at eight", 32'(status), 32'h0010_5000);
      chk("R5 tx valid with data", 32'(tx_valid), 32'h1);
      bus_write(8'h80, {8'(8'h63), 8'(8'h62), 8'(8'h61), 8'(8'h60)});
      chk("R9 tx half clears at nine", 32'(status), 32'h0010_1000);
      tx_ready = 1'b1;
      repeat (60) @(negedge clk);
      chk("R11 all bytes sent", 32'(snk_n), 32'd36);
      for (int i = 0; i < 36; i++) if (snk[i] !== 8'(i + 8'h40)) ok = 1'b0;
      chk("R4 byte order over nine words", 32'(ok), 32'h1);
      chk("R8 done after nine words", 32'(status), 32'h500);
   endtask

   task automatic t_rx_full_overlap();
      logic [31:0] v;
      logic [31:0] exp;
      int mism = 0;
      for (int i = 0; i < 80; i++) src[i] = 8'(i*7 + 3);
      src_n = 80;
      clear_streams();
      bus_write(A_LEN, 32'd80);
      bus_write(A_CTRL, 32'h03);
      repeat (100) @(negedge clk);
      chk("R9 rx full flags", 32'(status), 32'h0022_A000);
      chk("R5 rx stall at full", 32'(rx_ready), 32'h0);
      bus_read(A_BCNT, v); chk("R11 bytes left at full", v, 32'd16);
      for (int k = 0; k < 20; k++) begin
         wait_avail();
         bus_read(8'h90, v);
         exp = {8'((4*k+3)*7+3), 8'((4*k+2)*7+3), 8'((4*k+1)*7+3), 8'((4*k)*7+3)};
         if (v !== exp) begin
            mism++;
            $display("FAIL R3 overlap word %0d actual=%h expected=%h", k, v, exp);
         end
      end
      chk("R3 overlap words all match", 32'(mism), 32'h0);
      repeat (3) @(negedge clk);
      chk("R10 no error on overlap", 32'(xfer_err), 32'h0);
      chk("R8 rx long done", 32'(status), 32'h500);
   endtask

   task automatic t_overflow();
      logic [31:0] v;
      tx_ready = 1'b0;
      clear_streams();
      bus_write(A_LEN, 32'd80);
      bus_write(A_CTRL, 32'h01);
      for (int k = 0; k < 16; k++) bus_write(8'h80, 32'(k));
      chk("R10 no error before overflow", 32'(xfer_err), 32'h0);
      chk("R9 tx full flags", 32'(status), 32'h0011_1000);
      bus_write(8'h80, 32'hDEAD_BEEF);
      chk("R10 overflow sets error", 32'(xfer_err), 32'h1);
      bus_read(A_WCNT, v); chk("R6 word count after 17 writes", v, 32'd3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_zero_len();
      t_rx_short();
      t_tx_short();
      t_tx_half();
      t_rx_full_overlap();
      t_overflow();
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL R11 watchdog expired actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule